// File: doc/BRIEF.md
# Adaptive Redundancy Mode Controller

This block picks how much redundancy a processing function gets across a bank of reconfigurable regions, based on a measured upset rate. At a quiet rate one copy runs in one region. At a moderate rate two copies run side by side and their results are compared. At a high rate three copies run and a bitwise majority vote is taken. A hybrid switch lets a function that checks itself at the algorithm level stay on a single copy whatever the rate.

When more regions are needed, the controller sends a one-cycle load request to each region it adds. It keeps running in the old mode until every added region returns its done handshake, and only then switches. Dropping regions takes effect at once. Regions outside the current mode, and outside any load in progress, are held powered off.

Each valid set of results produces a registered voted word and a mismatch flag. Every region that disagrees gets a single scrub request, and it gets no further request until its scrub-done comes back. Votes taken while a load is in progress raise neither the flag nor any scrub.

Top module: `redund_mode_ctrl`

## Requirements
- R1: Mode is chosen from the unsigned rate (4 fractional bits): below 32 gives single (code 0), 32 to 127 gives pair (code 1), 128 and above gives triple (code 2). A rate change that keeps the same mode issues no load request.
- R2: With hybrid enabled and the self-checking flag set, the target mode is single at any rate. Clearing the flag restores the rate-based target.
- R3: Region enable is bit 0 in single, bits 0-1 in pair and bits 0-2 in triple. Region 3 is never enabled.
- R4: Power-off is set for every region that is neither enabled nor being loaded.
- R5: A move to a mode that uses more regions pulses a load request for one cycle on exactly the added regions. The mode and the enables keep their old values until a done has been seen for every added region, and change in the cycle after the last done.
- R6: A move to a mode that uses fewer regions takes effect one cycle after the rate changes, with no load request.
- R7: In triple mode the voted word is the bitwise majority of lanes 0, 1 and 2.
- R8: In triple mode the mismatch flag rises and scrub requests go only to the lanes that differ from the majority.
- R9: In pair mode the voted word is lane 0. Any bit difference between lanes 0 and 1 sets the mismatch flag and requests a scrub for both regions.
- R10: In single mode the voted word is lane 0 and the mismatch flag stays low whatever lanes 1 and 2 carry.
- R11: Results that are valid while a load is in progress produce a vote, but no mismatch flag and no scrub request.
- R12: A scrub request is a one-cycle pulse. The same region gets no new pulse until its scrub-done arrives.
- R13: After reset the mode is single, only region 0 is enabled, and no request or mismatch is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upset_rate_i | input | RATE_W | Measured upset rate, 4 fractional bits |
| hybrid_en_i | input | 1 | Enable the per-function hybrid policy |
| self_chk_i | input | 1 | Loaded function checks itself at algorithm level |
| res_vld_i | input | 1 | Result lanes valid this cycle |
| res_i | input | 3*DATA_W | Result lanes 0..2, lane 0 in the low bits |
| cfg_done_i | input | NUM_REG | Per-region load done pulse |
| scrub_done_i | input | NUM_REG | Per-region scrub done pulse |
| mode_o | output | 2 | Current mode: 0 single, 1 pair, 2 triple |
| region_en_o | output | NUM_REG | Per-region run enable |
| region_pwr_off_o | output | NUM_REG | Per-region power-off control |
| vote_vld_o | output | 1 | Voted word valid, one cycle after res_vld_i |
| vote_o | output | DATA_W | Voted or selected result |
| mismatch_o | output | 1 | Disagreement detected on this vote |
| cfg_req_o | output | NUM_REG | Per-region load request pulse |
| scrub_req_o | output | NUM_REG | Per-region scrub request pulse |

## Verification
The bench builds the block with a 16-bit data word, a 10-bit rate and the default thresholds of 32 and 128. This keeps lane values short enough to write out majority patterns with disjoint bits, while the rate still covers 31/32 and 127/128 and values well above the top threshold. Four regions are kept, so region 3 can be shown to stay off in every mode.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_PAIR   = 2'd1,
      MODE_TRIPLE = 2'd2
   } rmc_mode_e;

   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_LOAD = 1'b1
   } rmc_state_e;
endpackage

// File: rtl/rmc_mode_sel.sv
module rmc_mode_sel
   import rmc_pkg::*;
#(
   parameter int RATE_W   = 12,
   parameter int LOW_THR  = 32,
   parameter int HIGH_THR = 128
) (
   input  logic [RATE_W-1:0] rate_i,
   input  logic              hybrid_en_i,
   input  logic              self_chk_i,
   output rmc_mode_e         mode_o
);
   localparam logic [RATE_W-1:0] LO_CMP = LOW_THR[RATE_W-1:0];
   localparam logic [RATE_W-1:0] HI_CMP = HIGH_THR[RATE_W-1:0];

   always_comb begin
      if (hybrid_en_i && self_chk_i)  mode_o = MODE_SINGLE;
      else if (rate_i >= HI_CMP)      mode_o = MODE_TRIPLE;
      else if (rate_i >= LO_CMP)      mode_o = MODE_PAIR;
      else                            mode_o = MODE_SINGLE;
   end
endmodule

// File: rtl/rmc_voter.sv
module rmc_voter
   import rmc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_REG = 4
) (
   input  rmc_mode_e             mode_i,
   input  logic [3*DATA_W-1:0]   res_i,
   output logic [DATA_W-1:0]     vote_o,
   output logic [NUM_REG-1:0]    bad_o
);
   logic [DATA_W-1:0] lane_a, lane_b, lane_c, maj;

   assign lane_a = res_i[0*DATA_W +: DATA_W];
   assign lane_b = res_i[1*DATA_W +: DATA_W];
   assign lane_c = res_i[2*DATA_W +: DATA_W];
   assign maj    = (lane_a & lane_b) | (lane_a & lane_c) | (lane_b & lane_c);

   always_comb begin
      vote_o = lane_a;
      bad_o  = '0;
      unique case (mode_i)
         MODE_PAIR: begin
            bad_o[0] = (lane_a != lane_b);
            bad_o[1] = (lane_a != lane_b);
         end
         MODE_TRIPLE: begin
            vote_o   = maj;
            bad_o[0] = (lane_a != maj);
            bad_o[1] = (lane_b != maj);
            bad_o[2] = (lane_c != maj);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rmc_scrub_slot.sv
module rmc_scrub_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic done_i,
   output logic req_o
);
   logic busy_q, req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         req_q <= trig_i && !busy_q;
         if (trig_i && !busy_q) busy_q <= 1'b1;
         else if (done_i)       busy_q <= 1'b0;
      end
   end

   assign req_o = req_q;
endmodule

// File: rtl/redund_mode_ctrl.sv
module redund_mode_ctrl
   import rmc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int RATE_W      = 12,
   parameter int NUM_REG     = 4,
   parameter int FRAC_BITS   = 4,
   parameter int LOW_UPSETS  = 2,
   parameter int HIGH_UPSETS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [RATE_W-1:0]     upset_rate_i,
   input  logic                  hybrid_en_i,
   input  logic                  self_chk_i,
   input  logic                  res_vld_i,
   input  logic [3*DATA_W-1:0]   res_i,
   input  logic [NUM_REG-1:0]    cfg_done_i,
   input  logic [NUM_REG-1:0]    scrub_done_i,
   output logic [1:0]            mode_o,
   output logic [NUM_REG-1:0]    region_en_o,
   output logic [NUM_REG-1:0]    region_pwr_off_o,
   output logic                  vote_vld_o,
   output logic [DATA_W-1:0]     vote_o,
   output logic                  mismatch_o,
   output logic [NUM_REG-1:0]    cfg_req_o,
   output logic [NUM_REG-1:0]    scrub_req_o
);
   localparam int LOW_THR  = LOW_UPSETS  << FRAC_BITS;
   localparam int HIGH_THR = HIGH_UPSETS << FRAC_BITS;

   if (NUM_REG < 3) begin : g_chk_reg
      $error("redund_mode_ctrl: at least three regions are required");
   end
   if (LOW_THR >= HIGH_THR) begin : g_chk_thr
      $error("redund_mode_ctrl: lower threshold must be below upper threshold");
   end
   if (HIGH_THR >= (1 << RATE_W)) begin : g_chk_rate
      $error("redund_mode_ctrl: rate width cannot reach the upper threshold");
   end

   function automatic logic [NUM_REG-1:0] use_mask(rmc_mode_e m);
      logic [NUM_REG-1:0] r;
      r = '0;
      unique case (m)
         MODE_SINGLE: r[0]   = 1'b1;
         MODE_PAIR:   r[1:0] = 2'b11;
         MODE_TRIPLE: r[2:0] = 3'b111;
         default:     r      = '0;
      endcase
      return r;
   endfunction

   rmc_state_e          state_q;
   rmc_mode_e           mode_q, tgt_q, tgt_c;
   logic [NUM_REG-1:0]  pend_q, add_c, left_c, cfg_req_q, bad_c, trig_c;
   logic [DATA_W-1:0]   vote_c, vote_q;
   logic                vld_q, err_q;

   rmc_mode_sel #(
      .RATE_W   (RATE_W),
      .LOW_THR  (LOW_THR),
      .HIGH_THR (HIGH_THR)
   ) u_sel (
      .rate_i      (upset_rate_i),
      .hybrid_en_i (hybrid_en_i),
      .self_chk_i  (self_chk_i),
      .mode_o      (tgt_c)
   );

   rmc_voter #(
      .DATA_W  (DATA_W),
      .NUM_REG (NUM_REG)
   ) u_vote (
      .mode_i (mode_q),
      .res_i  (res_i),
      .vote_o (vote_c),
      .bad_o  (bad_c)
   );

   assign add_c  = use_mask(tgt_c) & ~use_mask(mode_q);
   assign left_c = pend_q & ~cfg_done_i;
   assign trig_c = (res_vld_i && state_q == ST_RUN) ? bad_c : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RUN;
         mode_q    <= MODE_SINGLE;
         tgt_q     <= MODE_SINGLE;
         pend_q    <= '0;
         cfg_req_q <= '0;
         vld_q     <= 1'b0;
         vote_q    <= '0;
         err_q     <= 1'b0;
      end else begin
         cfg_req_q <= '0;
         unique case (state_q)
            ST_RUN: begin
               if (tgt_c != mode_q) begin
                  if (add_c == '0) begin
                     mode_q <= tgt_c;
                  end else begin
                     state_q   <= ST_LOAD;
                     tgt_q     <= tgt_c;
                     pend_q    <= add_c;
                     cfg_req_q <= add_c;
                  end
               end
            end
            ST_LOAD: begin
               pend_q <= left_c;
               if (left_c == '0) begin
                  mode_q  <= tgt_q;
                  state_q <= ST_RUN;
               end
            end
            default: state_q <= ST_RUN;
         endcase
         vld_q <= res_vld_i;
         if (res_vld_i) vote_q <= vote_c;
         err_q <= |trig_c;
      end
   end

   for (genvar g = 0; g < NUM_REG; g++) begin : g_scrub
      rmc_scrub_slot u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .trig_i (trig_c[g]),
         .done_i (scrub_done_i[g]),
         .req_o  (scrub_req_o[g])
      );
   end

   assign mode_o           = mode_q;
   assign region_en_o      = use_mask(mode_q);
   assign region_pwr_off_o = ~(use_mask(mode_q) | ((state_q == ST_LOAD) ? use_mask(tgt_q) : '0));
   assign vote_vld_o       = vld_q;
   assign vote_o           = vote_q;
   assign mismatch_o       = err_q;
   assign cfg_req_o        = cfg_req_q;
endmodule

// File: rtl/rmc_ctrl_chk.sv
module rmc_ctrl_chk #(
   parameter int NUM_REG = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_o,
   input logic [NUM_REG-1:0] region_en_o,
   input logic [NUM_REG-1:0] region_pwr_off_o,
   input logic               vote_vld_o,
   input logic               mismatch_o,
   input logic [NUM_REG-1:0] cfg_req_o,
   input logic [NUM_REG-1:0] scrub_req_o
);
   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'd3); // R1
   AST_POWER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (region_en_o & region_pwr_off_o) == '0); // R4
   AST_CFG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_o != '0) |=> (cfg_req_o == '0)); // R5
   AST_SCRUB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (scrub_req_o & $past(scrub_req_o)) == '0); // R12
   AST_SINGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch_o |-> ($past(mode_o) != 2'd0)); // R10
   AST_ERR_HAS_VOTE: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch_o |-> vote_vld_o); // R11
endmodule

bind redund_mode_ctrl rmc_ctrl_chk #(.NUM_REG(NUM_REG)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .mode_o           (mode_o),
   .region_en_o      (region_en_o),
   .region_pwr_off_o (region_pwr_off_o),
   .vote_vld_o       (vote_vld_o),
   .mismatch_o       (mismatch_o),
   .cfg_req_o        (cfg_req_o),
   .scrub_req_o      (scrub_req_o)
);

// File: tb/redund_mode_ctrl_tb.sv
module redund_mode_ctrl_tb;
   localparam int DW = 16;
   localparam int RW = 10;
   localparam int NR = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [RW-1:0]     rate = '0;
   logic              hyb = 1'b0, selfc = 1'b0, vld = 1'b0;
   logic [3*DW-1:0]   res = '0;
   logic [NR-1:0]     cdone = '0, sdone = '0;
   logic [1:0]        mode;
   logic [NR-1:0]     en, poff, creq, sreq;
   logic              vvld, merr;
   logic [DW-1:0]     vote;
   int                checks = 0, errors = 0;

   always #5 clk = ~clk;

   redund_mode_ctrl #(.DATA_W(DW), .RATE_W(RW), .NUM_REG(NR)) u_dut (
      .clk(clk), .rst_n(rst_n), .upset_rate_i(rate), .hybrid_en_i(hyb),
      .self_chk_i(selfc), .res_vld_i(vld), .res_i(res), .cfg_done_i(cdone),
      .scrub_done_i(sdone), .mode_o(mode), .region_en_o(en),
      .region_pwr_off_o(poff), .vote_vld_o(vvld), .vote_o(vote),
      .mismatch_o(merr), .cfg_req_o(creq), .scrub_req_o(sreq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic vote_in(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] c);
      res = {c, b, a}; vld = 1'b1; tick(); vld = 1'b0;
   endtask

   task automatic clear_scrub();
      sdone = '1; tick(); sdone = '0;
   endtask

   task automatic t_reset();
      chk("R13 mode", 32'(mode), 0);
      chk("R13 en", 32'(en), 32'h1);
      chk("R13 poff", 32'(poff), 32'hE);
      chk("R13 req", 32'({creq, sreq, merr}), 0);
   endtask

   task automatic t_single();
      vote_in(16'h1234, 16'hFFFF, 16'h0000);
      chk("R10 vote", 32'(vote), 32'h1234);
      chk("R10 err", 32'(merr), 0);
      chk("R10 scrub", 32'(sreq), 0);
      rate = 10'd31; tick(); tick();
      chk("R1 31 single", 32'(mode), 0);
      chk("R1 31 no load", 32'(creq), 0);
   endtask

   task automatic t_to_pair();
      rate = 10'd32; tick();
      chk("R5 load req", 32'(creq), 32'h2);
      chk("R5 mode held", 32'(mode), 0);
      chk("R4 poff loading", 32'(poff), 32'hC);
      tick();
      chk("R5 req pulse", 32'(creq), 0);
      chk("R5 still old", 32'(en), 32'h1);
      cdone = 4'h2; tick(); cdone = '0;
      chk("R1 pair", 32'(mode), 1);
      chk("R3 pair en", 32'(en), 32'h3);
      chk("R4 pair poff", 32'(poff), 32'hC);
   endtask

   task automatic t_pair();
      vote_in(16'hAAAA, 16'hAAAB, 16'h0000);
      chk("R9 vote", 32'(vote), 32'hAAAA);
      chk("R9 err", 32'(merr), 1);
      chk("R9 scrub", 32'(sreq), 32'h3);
      vote_in(16'hAAAA, 16'hAAAB, 16'h0000);
      chk("R12 err again", 32'(merr), 1);
      chk("R12 no reissue", 32'(sreq), 0);
      clear_scrub();
      vote_in(16'h5555, 16'h5555, 16'h0001);
      chk("R9 equal", 32'({merr, sreq}), 0);
      vote_in(16'h0001, 16'h0000, 16'h0000);
      chk("R12 after done", 32'(sreq), 32'h3);
      clear_scrub();
      rate = 10'd127; tick(); tick();
      chk("R1 127 pair", 32'(mode), 1);
   endtask

   task automatic t_to_triple();
      rate = 10'd128; tick();
      chk("R5 triple req", 32'(creq), 32'h4);
      vote_in(16'h0F0F, 16'hF0F0, 16'h1111);
      chk("R11 vote valid", 32'(vvld), 1);
      chk("R11 no err", 32'(merr), 0);
      chk("R11 no scrub", 32'(sreq), 0);
      cdone = 4'h4; tick(); cdone = '0;
      chk("R1 triple", 32'(mode), 2);
      chk("R3 triple en", 32'(en), 32'h7);
      chk("R4 triple poff", 32'(poff), 32'h8);
   endtask

   task automatic t_triple();
      vote_in(16'hC3C3, 16'hC3C3, 16'h3C3C);
      chk("R7 vote", 32'(vote), 32'hC3C3);
      chk("R8 err", 32'(merr), 1);
      chk("R8 scrub lane2", 32'(sreq), 32'h4);
      clear_scrub();
      vote_in(16'h00FF, 16'h0F0F, 16'h3333);
      chk("R7 majority", 32'(vote), 32'h033F);
      chk("R8 all lanes", 32'(sreq), 32'h7);
      clear_scrub();
   endtask

   task automatic t_drop();
      rate = 10'd0; tick();
      chk("R6 mode", 32'(mode), 0);
      chk("R6 no req", 32'(creq), 0);
      chk("R4 single poff", 32'(poff), 32'hE);
   endtask

   task automatic t_hybrid();
      hyb = 1'b1; selfc = 1'b1; rate = 10'd300; tick(); tick();
      chk("R2 stays single", 32'(mode), 0);
      chk("R2 no req", 32'(creq), 0);
      selfc = 1'b0; tick();
      chk("R2 triple load", 32'(creq), 32'h6);
      cdone = 4'h2; tick();
      chk("R5 partial done", 32'(mode), 0);
      cdone = 4'h4; tick(); cdone = '0;
      chk("R2 triple", 32'(mode), 2);
      selfc = 1'b1; tick();
      chk("R2 back single", 32'(en), 32'h1);
   endtask

   initial begin
      fork
         begin
            repeat (3) tick();
            rst_n = 1'b1;
            tick();
            t_reset();
            t_single();
            t_to_pair();
            t_pair();
            t_to_triple();
            t_triple();
            t_drop();
            t_hybrid();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule